// File: doc/BRIEF.md
# Masked Internal Control-Register Bank

This block holds the processor's internal control registers: 64 slots of 64 bits, selected by a 7-bit index on a read port and on a write port. Each register carries its own write mask, its own access rights (read-write, read-only, write-only), and for some registers a side effect. A read returns data combinationally in the request cycle. A write lands on the next rising clock edge. Both ports raise a combinational fault flag when the access is not legal. The flag stands for an unimplemented-opcode fault, which the pipeline turns into a trap.

Writes to the TLB invalidate registers do not simply store a value. Each one sends a one-cycle strobe to the TLBs, together with the address and address-space number when a single entry is meant. The cycle-counter register reads back as a composite of its stored upper half and a free-running cycle count. Reading the virtual-address register releases the interrupt lock flag, which the interrupt logic sets through `lock_set`.

Top module: `ctl_reg_bank`

## Requirements
- R1: A legal write stores `wr_data & mask`, where the mask depends on the index. Index 26 and 27 use 0xf. 28 uses 0x1f. 29, 30 and 31 use 0x18. 32 uses 0x7fff0. 33 uses 0xffffff0300. 34 and 35 use 0xffffffffc0000000. 36 and 37 use 0x3f. 38 uses 0x1ffb. 39 uses 0x7f0. 40 uses 0xfe00000000000000. Every other storing index keeps all 64 bits. Indices 0-23 are scratch registers, 24 is the privileged base, 60 is the control-status register and 61-63 are plain counters or status registers.
- R2: A write to the exception-address register (index 25) always stores bit 1 as zero and keeps every other bit.
- R3: Any write to the exception summary (index 41) or the exception mask (index 42) leaves that register at zero, whatever the data.
- R4: A write to a read-only index raises `wr_fault` and changes no register. The read-only indices are 43-47 and the virtual-address register 59.
- R5: A read of a write-only index raises `rd_fault` and returns zero on `rd_data`. The write-only indices are 31, 35, 38-40 and 48-57. A write to these indices does not fault.
- R6: An index of 64 or above raises the fault on both the read port and the write port.
- R7: A write to index 52 (data TLB invalidate-all), 53 (data TLB invalidate-process), 54 (instruction TLB invalidate-all) or 55 (instruction TLB invalidate-process) stores zero. It raises the matching strobe for exactly the one cycle after the write edge.
- R8: A write to index 56 (data single invalidate) or 57 (instruction single invalidate) stores the value. During the following cycle it pulses `dtlb_inv_addr` or `itlb_inv_addr`, with `inv_va` equal to the written value. `inv_asn` carries bits [63:57] of index 40 for a data flush, or bits [10:4] of index 39 for an instruction flush.
- R9: A read of index 58 returns the stored bits [63:32] above the lower 32 bits of a cycle count. The count is cleared by reset and increments on every clock.
- R10: A legal read of index 59 clears `intr_lock` at the next edge. `lock_set` sets the flag when no such read happens in the same cycle. Reads of other indices leave the flag unchanged.
- R11: After reset every register reads zero, except index 24, which holds the `BASE_RESET` parameter, and index 60, which holds 0x6. `intr_lock` and all strobes are low.
- R12: `rd_fault` and `wr_fault` are combinational and valid in the same cycle as the request. Both are low when the matching enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read request |
| rd_idx | input | 7 | Read index |
| rd_data | output | 64 | Read data, combinational |
| rd_fault | output | 1 | Illegal read, combinational |
| wr_en | input | 1 | Write request |
| wr_idx | input | 7 | Write index |
| wr_data | input | 64 | Write data |
| wr_fault | output | 1 | Illegal write, combinational |
| lock_set | input | 1 | Sets the interrupt lock flag |
| intr_lock | output | 1 | Interrupt lock flag |
| dtlb_inv_all | output | 1 | Data TLB flush-all strobe |
| dtlb_inv_proc | output | 1 | Data TLB flush-process strobe |
| itlb_inv_all | output | 1 | Instruction TLB flush-all strobe |
| itlb_inv_proc | output | 1 | Instruction TLB flush-process strobe |
| dtlb_inv_addr | output | 1 | Data TLB single-entry flush strobe |
| itlb_inv_addr | output | 1 | Instruction TLB single-entry flush strobe |
| inv_va | output | 64 | Address for a single-entry flush |
| inv_asn | output | 7 | Address-space number for a single-entry flush |

## Verification
The write path is tested with all-ones data, which shows the full keep-mask of each register. Sparse patterns then show that masked-off bits are dropped and kept bits are not shifted. Pairs of patterns on the exception-address register tell apart a forced zero on bit 1 from a mask that drops more. Clear-on-write registers get non-zero data to prove the value is discarded. The access classes are tested by touching one read-only index, one write-only index and one out-of-range index, each on both ports. The cycle counter is read twice, a known number of cycles apart, which separates the counting half from the stored half.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;

  localparam int XLEN   = 64;
  localparam int IDX_W  = 7;
  localparam int NSLOT  = 64;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int ASN_W  = 7;
  localparam int CNT_W  = XLEN / 2;

  typedef enum logic [1:0] {ACC_NONE, ACC_RW, ACC_RO, ACC_WO} acc_e;
  typedef enum logic       {WK_MASK, WK_ZERO} wkind_e;

  localparam logic [IDX_W-1:0] IX_PRIV_BASE = 7'd24;
  localparam logic [IDX_W-1:0] IX_EXC_ADDR  = 7'd25;
  localparam logic [IDX_W-1:0] IX_IASN      = 7'd39;
  localparam logic [IDX_W-1:0] IX_DASN      = 7'd40;
  localparam logic [IDX_W-1:0] IX_EXC_SUM   = 7'd41;
  localparam logic [IDX_W-1:0] IX_EXC_MSK   = 7'd42;
  localparam logic [IDX_W-1:0] IX_D_INV_ALL = 7'd52;
  localparam logic [IDX_W-1:0] IX_D_INV_PRC = 7'd53;
  localparam logic [IDX_W-1:0] IX_I_INV_ALL = 7'd54;
  localparam logic [IDX_W-1:0] IX_I_INV_PRC = 7'd55;
  localparam logic [IDX_W-1:0] IX_D_INV_ONE = 7'd56;
  localparam logic [IDX_W-1:0] IX_I_INV_ONE = 7'd57;
  localparam logic [IDX_W-1:0] IX_CYCLE     = 7'd58;
  localparam logic [IDX_W-1:0] IX_VADDR     = 7'd59;
  localparam logic [IDX_W-1:0] IX_CTL_STAT  = 7'd60;

  localparam logic [XLEN-1:0] CTL_STAT_RST = 64'h6;

  // Access class of an index
  function automatic acc_e acc_class(input logic [IDX_W-1:0] ix);
    if (ix < 7'd24) return ACC_RW;
    case (ix)
      7'd24, 7'd25, 7'd26, 7'd27, 7'd28, 7'd29, 7'd30, 7'd32, 7'd33,
      7'd34, 7'd36, 7'd37, 7'd41, 7'd42, 7'd58, 7'd60, 7'd61, 7'd62,
      7'd63:                                   return ACC_RW;
      7'd43, 7'd44, 7'd45, 7'd46, 7'd47, 7'd59: return ACC_RO;
      7'd31, 7'd35, 7'd38, 7'd39, 7'd40, 7'd48, 7'd49, 7'd50, 7'd51,
      7'd52, 7'd53, 7'd54, 7'd55, 7'd56, 7'd57: return ACC_WO;
      default:                                 return ACC_NONE;
    endcase
  endfunction

  // Bits kept by a write
  function automatic logic [XLEN-1:0] wr_mask(input logic [IDX_W-1:0] ix);
    case (ix)
      7'd25:               return ~64'h2;
      7'd26, 7'd27:        return 64'hf;
      7'd28:               return 64'h1f;
      7'd29, 7'd30, 7'd31: return 64'h18;
      7'd32:               return 64'h7fff0;
      7'd33:               return 64'hff_ffff_0300;
      7'd34, 7'd35:        return 64'hffff_ffff_c000_0000;
      7'd36, 7'd37:        return 64'h3f;
      7'd38:               return 64'h1ffb;
      7'd39:               return 64'h7f0;
      7'd40:               return 64'hfe00_0000_0000_0000;
      default:             return '1;
    endcase
  endfunction

  // Registers that store zero on any write
  function automatic wkind_e wr_kind(input logic [IDX_W-1:0] ix);
    case (ix)
      IX_EXC_SUM, IX_EXC_MSK, IX_D_INV_ALL, IX_D_INV_PRC,
      IX_I_INV_ALL, IX_I_INV_PRC: return WK_ZERO;
      default:                    return WK_MASK;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] slot_reset(input int slot,
                                                  input logic [XLEN-1:0] base);
    if (slot == int'(IX_PRIV_BASE)) return base;
    if (slot == int'(IX_CTL_STAT))  return CTL_STAT_RST;
    return '0;
  endfunction

  function automatic logic [XLEN-1:0] cyc_compose(input logic [XLEN-1:0] stored,
                                                   input logic [CNT_W-1:0] cnt);
    return {stored[XLEN-1:CNT_W], cnt};
  endfunction

endpackage

// File: rtl/ctl_reg_decode.sv
module ctl_reg_decode
  import ctl_reg_pkg::*;
(
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             rd_fault,
  output logic             rd_blank,
  output logic             wr_fault,
  output logic             wr_take,
  output logic [XLEN-1:0]  wmask,
  output wkind_e           wkind
);
  acc_e rd_cls, wr_cls;

  always_comb begin
    rd_cls   = acc_class(rd_idx);
    wr_cls   = acc_class(wr_idx);
    rd_fault = rd_en && !(rd_cls == ACC_RW || rd_cls == ACC_RO);
    rd_blank = !(rd_cls == ACC_RW || rd_cls == ACC_RO);
    wr_fault = wr_en && !(wr_cls == ACC_RW || wr_cls == ACC_WO);
    wr_take  = wr_en && (wr_cls == ACC_RW || wr_cls == ACC_WO);
    wmask    = wr_mask(wr_idx);
    wkind    = wr_kind(wr_idx);
  end
endmodule

// File: rtl/ctl_reg_store.sv
module ctl_reg_store
  import ctl_reg_pkg::*;
#(
  parameter logic [XLEN-1:0] BASE_RESET = 64'h0000_0000_0002_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_take,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [XLEN-1:0]   wr_data,
  input  logic [XLEN-1:0]   wmask,
  input  wkind_e            wkind,
  output logic [XLEN-1:0]   regs_q [NSLOT]
);
  logic [XLEN-1:0] nxt;

  always_comb nxt = (wkind == WK_ZERO) ? '0 : (wr_data & wmask);

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[g] <= slot_reset(g, BASE_RESET);
      else if (wr_take && wr_slot == SLOT_W'(g))
        regs_q[g] <= nxt;
    end
  end
endmodule

// File: rtl/ctl_flush_gen.sv
module ctl_flush_gen
  import ctl_reg_pkg::*;
#(
  parameter int NSTB = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_take,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [ASN_W-1:0] d_asn,
  input  logic [ASN_W-1:0] i_asn,
  output logic [NSTB-1:0]  stb_q,
  output logic [XLEN-1:0]  va_q,
  output logic [ASN_W-1:0] asn_q
);
  // strobe order: d-all, d-proc, i-all, i-proc, d-one, i-one
  localparam logic [IDX_W-1:0] STB_IX [NSTB] = '{IX_D_INV_ALL, IX_D_INV_PRC,
                                                IX_I_INV_ALL, IX_I_INV_PRC,
                                                IX_D_INV_ONE, IX_I_INV_ONE};

  for (genvar k = 0; k < NSTB; k++) begin : g_stb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_q[k] <= 1'b0;
      else        stb_q[k] <= wr_take && (wr_idx == STB_IX[k]);
    end
  end

  logic single_d, single_i;
  always_comb begin
    single_d = wr_take && (wr_idx == IX_D_INV_ONE);
    single_i = wr_take && (wr_idx == IX_I_INV_ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q  <= '0;
      asn_q <= '0;
    end else if (single_d || single_i) begin
      va_q  <= wr_data;
      asn_q <= single_d ? d_asn : i_asn;
    end
  end
endmodule

// File: rtl/ctl_cycle_ctr.sv
module ctl_cycle_ctr #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + W'(1);
  end
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
  import ctl_reg_pkg::*;
#(
  parameter logic [63:0] BASE_RESET = 64'h0000_0000_0002_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic [6:0]  rd_idx,
  output logic [63:0] rd_data,
  output logic        rd_fault,
  input  logic        wr_en,
  input  logic [6:0]  wr_idx,
  input  logic [63:0] wr_data,
  output logic        wr_fault,
  input  logic        lock_set,
  output logic        intr_lock,
  output logic        dtlb_inv_all,
  output logic        dtlb_inv_proc,
  output logic        itlb_inv_all,
  output logic        itlb_inv_proc,
  output logic        dtlb_inv_addr,
  output logic        itlb_inv_addr,
  output logic [63:0] inv_va,
  output logic [6:0]  inv_asn
);
  localparam int NSTB = 6;

  // named internal events for the checker
  logic            wr_take;
  logic            rd_blank;
  logic            va_read;
  logic [XLEN-1:0] wmask;
  wkind_e          wkind;
  logic [XLEN-1:0] regs_q [NSLOT];
  logic [CNT_W-1:0] cyc_cnt;
  logic [NSTB-1:0] stb_q;

  ctl_reg_decode u_dec (
    .rd_en    (rd_en),
    .rd_idx   (rd_idx),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .rd_fault (rd_fault),
    .rd_blank (rd_blank),
    .wr_fault (wr_fault),
    .wr_take  (wr_take),
    .wmask    (wmask),
    .wkind    (wkind)
  );

  ctl_reg_store #(.BASE_RESET(BASE_RESET)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_take (wr_take),
    .wr_slot (wr_idx[SLOT_W-1:0]),
    .wr_data (wr_data),
    .wmask   (wmask),
    .wkind   (wkind),
    .regs_q  (regs_q)
  );

  ctl_flush_gen #(.NSTB(NSTB)) u_flush (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_take (wr_take),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .d_asn   (regs_q[IX_DASN[SLOT_W-1:0]][XLEN-1 -: ASN_W]),
    .i_asn   (regs_q[IX_IASN[SLOT_W-1:0]][4 +: ASN_W]),
    .stb_q   (stb_q),
    .va_q    (inv_va),
    .asn_q   (inv_asn)
  );

  ctl_cycle_ctr #(.W(CNT_W)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .count (cyc_cnt)
  );

  always_comb begin
    if (rd_blank)
      rd_data = '0;
    else if (rd_idx == IX_CYCLE)
      rd_data = cyc_compose(regs_q[IX_CYCLE[SLOT_W-1:0]], cyc_cnt);
    else
      rd_data = regs_q[rd_idx[SLOT_W-1:0]];
  end

  assign va_read = rd_en && (rd_idx == IX_VADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        intr_lock <= 1'b0;
    else if (va_read)  intr_lock <= 1'b0;
    else if (lock_set) intr_lock <= 1'b1;
  end

  assign dtlb_inv_all  = stb_q[0];
  assign dtlb_inv_proc = stb_q[1];
  assign itlb_inv_all  = stb_q[2];
  assign itlb_inv_proc = stb_q[3];
  assign dtlb_inv_addr = stb_q[4];
  assign itlb_inv_addr = stb_q[5];
endmodule

// File: rtl/ctl_reg_bank_chk.sv
module ctl_reg_bank_chk
  import ctl_reg_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic [6:0]  rd_idx,
  input logic [63:0] rd_data,
  input logic        rd_fault,
  input logic        wr_en,
  input logic [6:0]  wr_idx,
  input logic        wr_fault,
  input logic        wr_take,
  input logic        lock_set,
  input logic        intr_lock,
  input logic        dtlb_inv_all,
  input logic        dtlb_inv_proc,
  input logic        itlb_inv_all,
  input logic        itlb_inv_proc,
  input logic        dtlb_inv_addr,
  input logic        itlb_inv_addr
);
  p_excaddr_bit1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == IX_EXC_ADDR) |-> (rd_data[1] == 1'b0));

  p_clear_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IX_EXC_SUM) |=>
      !(rd_en && rd_idx == IX_EXC_SUM && rd_data != '0));

  p_faulted_write_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fault |-> !wr_take);

  p_unknown_idx_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx[6]) |-> rd_fault);

  p_flush_all_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dtlb_inv_all) |-> $past(wr_en && wr_idx == IX_D_INV_ALL));

  p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dtlb_inv_all, dtlb_inv_proc, itlb_inv_all, itlb_inv_proc,
              dtlb_inv_addr, itlb_inv_addr}));

  p_lock_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == IX_VADDR) |=> !intr_lock);

  p_no_fault_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !wr_en) |-> (!rd_fault && !wr_fault));

  logic unused_ok;
  assign unused_ok = lock_set;
endmodule

bind ctl_reg_bank ctl_reg_bank_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_en         (rd_en),
  .rd_idx        (rd_idx),
  .rd_data       (rd_data),
  .rd_fault      (rd_fault),
  .wr_en         (wr_en),
  .wr_idx        (wr_idx),
  .wr_fault      (wr_fault),
  .wr_take       (wr_take),
  .lock_set      (lock_set),
  .intr_lock     (intr_lock),
  .dtlb_inv_all  (dtlb_inv_all),
  .dtlb_inv_proc (dtlb_inv_proc),
  .itlb_inv_all  (itlb_inv_all),
  .itlb_inv_proc (itlb_inv_proc),
  .dtlb_inv_addr (dtlb_inv_addr),
  .itlb_inv_addr (itlb_inv_addr)
);

// File: tb/ctl_reg_bank_bench.sv
module ctl_reg_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] BASE = 64'h0000_0000_0002_0000;
  localparam int NV = 18;

  localparam logic [6:0] TV_IDX [NV] = '{7'd3, 7'd24, 7'd25, 7'd25, 7'd26, 7'd27,
    7'd28, 7'd29, 7'd30, 7'd32, 7'd33, 7'd34, 7'd36, 7'd37, 7'd41, 7'd42, 7'd60, 7'd63};
  localparam logic [63:0] TV_DATA [NV] = '{64'hA5A5_5A5A_F00F_0FF0,
    64'h1234_5678_9abc_def0, '1, 64'h0000_0000_0000_0007, 64'hff, 64'h1235,
    64'hffff, 64'hff, 64'h10, '1, '1, '1, 64'hffff, 64'h55, '1, 64'h1234,
    64'h99, '1};
  localparam logic [63:0] TV_MASK [NV] = '{'1, '1, ~64'h2, ~64'h2, 64'hf, 64'hf,
    64'h1f, 64'h18, 64'h18, 64'h7fff0, 64'hff_ffff_0300, 64'hffff_ffff_c000_0000,
    64'h3f, 64'h3f, 64'h0, 64'h0, '1, '1};
  localparam string TV_REQ [NV] = '{"R1", "R1", "R2", "R2", "R1", "R1", "R1", "R1",
    "R1", "R1", "R1", "R1", "R1", "R1", "R3", "R3", "R1", "R1"};

  logic        clk = 0, rst_n = 0;
  logic        rd_en = 0, wr_en = 0, lock_set = 0;
  logic [6:0]  rd_idx = 0, wr_idx = 0;
  logic [63:0] wr_data = 0;
  logic [63:0] rd_data, inv_va;
  logic        rd_fault, wr_fault, intr_lock;
  logic        dtlb_inv_all, dtlb_inv_proc, itlb_inv_all, itlb_inv_proc;
  logic        dtlb_inv_addr, itlb_inv_addr;
  logic [6:0]  inv_asn;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_reg_bank #(.BASE_RESET(BASE)) u_ctl_reg_bank (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_idx(rd_idx), .rd_data(rd_data),
    .rd_fault(rd_fault), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_fault(wr_fault), .lock_set(lock_set), .intr_lock(intr_lock),
    .dtlb_inv_all(dtlb_inv_all), .dtlb_inv_proc(dtlb_inv_proc),
    .itlb_inv_all(itlb_inv_all), .itlb_inv_proc(itlb_inv_proc),
    .dtlb_inv_addr(dtlb_inv_addr), .itlb_inv_addr(itlb_inv_addr),
    .inv_va(inv_va), .inv_asn(inv_asn));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [6:0] ix, input logic [63:0] d, output logic flt);
    @(negedge clk);
    wr_en = 1; wr_idx = ix; wr_data = d;
    #1 flt = wr_fault;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_read(input logic [6:0] ix, output logic [63:0] d, output logic flt);
    @(negedge clk);
    rd_en = 1; rd_idx = ix;
    #1 begin d = rd_data; flt = rd_fault; end
    @(negedge clk);
    rd_en = 0;
  endtask

  function automatic logic [5:0] strobes();
    return {itlb_inv_addr, dtlb_inv_addr, itlb_inv_proc, itlb_inv_all,
            dtlb_inv_proc, dtlb_inv_all};
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d, d2;
    logic f;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11: reset state
    do_read(7'd24, d, f); check("R11 base", d, BASE);
    do_read(7'd60, d, f); check("R11 ctl-stat", d, 64'h6);
    do_read(7'd0, d, f);  check("R11 scratch", d, 64'h0);
    do_read(7'd41, d, f); check("R11 exc-sum", d, 64'h0);
    check("R11 lock", {63'd0, intr_lock}, 64'h0);
    check("R11 strobes", {58'd0, strobes()}, 64'h0);
    // R12: idle gives no fault
    check("R12 idle", {62'd0, rd_fault, wr_fault}, 64'h0);

    // R1/R2/R3: table walk
    for (int i = 0; i < NV; i++) begin
      do_write(TV_IDX[i], TV_DATA[i], f);
      check({TV_REQ[i], " R12 wr-fault"}, {63'd0, f}, 64'h0);
      do_read(TV_IDX[i], d, f);
      check(TV_REQ[i], d, TV_DATA[i] & TV_MASK[i]);
    end

    // R4: read-only write faults, register unchanged
    do_write(7'd45, 64'hffff, f); check("R4 fault", {63'd0, f}, 64'h1);
    do_read(7'd45, d, f);
    check("R4 unchanged", d, 64'h0); check("R4 read ok", {63'd0, f}, 64'h0);

    // R5: write-only read faults with zero data; write does not fault
    do_write(7'd50, 64'h77, f); check("R5 wr ok", {63'd0, f}, 64'h0);
    do_read(7'd50, d, f);
    check("R5 fault", {63'd0, f}, 64'h1); check("R5 data", d, 64'h0);

    // R6: unknown index faults both ways; R12 same-cycle
    do_read(7'd100, d, f); check("R6 R12 rd", {63'd0, f}, 64'h1);
    do_write(7'd100, 64'h1, f); check("R6 R12 wr", {63'd0, f}, 64'h1);

    // R7: invalidate-all / process strobes for one cycle
    do_write(7'd52, 64'h55, f); check("R7 d-all on", {58'd0, strobes()}, 64'h01);
    @(negedge clk); check("R7 d-all off", {58'd0, strobes()}, 64'h0);
    do_write(7'd55, 64'h55, f); check("R7 i-proc on", {58'd0, strobes()}, 64'h08);
    @(negedge clk); check("R7 i-proc off", {58'd0, strobes()}, 64'h0);
    do_write(7'd53, 64'h1, f); check("R7 d-proc on", {58'd0, strobes()}, 64'h02);
    do_write(7'd54, 64'h1, f); check("R7 i-all on", {58'd0, strobes()}, 64'h04);

    // R8: single-entry flush with ASN
    do_write(7'd40, 64'h5400_0000_0000_0000, f);
    do_write(7'd56, 64'h1234_5000, f);
    check("R8 d-one", {58'd0, strobes()}, 64'h10);
    check("R8 d-va", inv_va, 64'h1234_5000);
    check("R8 d-asn", {57'd0, inv_asn}, 64'h2a);
    do_write(7'd39, 64'hf3a5, f);
    do_write(7'd57, 64'h8000_0000_0000_2000, f);
    check("R8 i-one", {58'd0, strobes()}, 64'h20);
    check("R8 i-va", inv_va, 64'h8000_0000_0000_2000);
    check("R8 i-asn", {57'd0, inv_asn}, 64'h3a);

    // R9: cycle counter composite
    do_write(7'd58, 64'hDEAD_BEEF_1234_5678, f);
    do_read(7'd58, d, f);
    repeat (4) @(negedge clk);
    do_read(7'd58, d2, f);
    check("R9 upper", {32'd0, d[63:32]}, 64'hDEAD_BEEF);
    check("R9 count", {32'd0, d2[31:0] - d[31:0]}, 64'd6);

    // R10: interrupt lock
    @(negedge clk); lock_set = 1;
    @(negedge clk); lock_set = 0;
    check("R10 set", {63'd0, intr_lock}, 64'h1);
    do_read(7'd0, d, f); check("R10 other read keeps", {63'd0, intr_lock}, 64'h1);
    do_read(7'd59, d, f); check("R10 cleared", {63'd0, intr_lock}, 64'h0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule